// File: doc/BRIEF.md
# Time-Multiplexed Three-Tap FIR Cluster

This block evaluates three consecutive taps of a programmable-coefficient FIR filter on one shared multiply-accumulate datapath. It is clocked at three times the sample rate. A free-running modulo-3 phase counter steers everything in the block: which stored coefficient and which delayed sample reach the multiplier, when the accumulation input is merged, and when a new sample is taken. The multiplier output stays in carry-save form as two partial products. A 4:2 compressor folds these into a carry-save running sum. That running sum is seeded once per sample period from the carry-save accumulation input.

Clusters are chained to build longer filters. The broadcast output carries the input samples delayed by four sample periods. The accumulation output feeds the accumulation input of the next cluster. Each later cluster is built with its phase offset advanced by 2 (mod 3). A carry-propagate merge of the last cluster's two output words yields the filter output. Coefficients are written one tap at a time into a shadow bank. That bank is copied into the working bank only at the edge where a new sample is taken, so no sample ever sees a mix of old and new coefficients.

Top module: `fir3_cluster`

## Requirements
- R1: While reset is asserted, and at the first rising edge after it is released, `phase` equals `PHASE_OFS` and `acc_out_s`, `acc_out_c` and `bcast_out` are all zero.
- R2: `phase` steps 0→1→2→0 on every rising clock edge.
- R3: `x_in` is captured at each edge that ends a phase-0 cycle. Call that edge T and the sample x[n]. At edge T+5 (which ends a phase-2 cycle) the sum `acc_out_s + acc_out_c` mod 2^AW becomes A + c0·x[n] + c1·x[n−1] + c2·x[n−2]. Here A = `acc_in_s + acc_in_c` sampled at edge T+2, and c0..c2 are the working coefficients. The outputs change only at edges that end phase-2 cycles.
- R4: Samples and coefficients are two's complement. The result is exact modulo 2^AW, including the extremes −128 and −2048.
- R5: With all coefficients zero, the output sum equals the carry-save accumulation input, whatever split is used between its two words.
- R6: `bcast_out` equals the sample captured four sample periods before the latest capture. It changes only at edges that end phase-0 cycles.
- R7: A write with `coef_wr`=1 and `coef_sel` = 0, 1 or 2 stores `coef_data` in the shadow entry for that tap (0 multiplies the newest sample). A write made during a phase-1 or phase-2 cycle takes effect for the sample captured at the next phase-0-ending edge.
- R8: A write made during a phase-0 cycle lands on the same edge as the shadow-to-working copy. It therefore applies from the sample after the one captured at that edge.
- R9: A write with `coef_sel` = 3 changes no coefficient.
- R10: A second cluster with `PHASE_OFS` = 2 takes `bcast_out` and the accumulation outputs of a first cluster with `PHASE_OFS` = 0. After merging, the second cluster's output is y[m] = Σ_{j=0..5} h_j·x[m−j]. Here h0..h2 are the first cluster's coefficients and h3..h5 are the second's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at three times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | DW | Sample input, two's complement |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Tap index of the write (3 = no target) |
| coef_data | input | CW | Coefficient value, two's complement |
| acc_in_s | input | AW | Accumulation input, sum word |
| acc_in_c | input | AW | Accumulation input, carry word |
| phase | output | 2 | Current schedule phase (0..2) |
| bcast_out | output | DW | Samples delayed by four periods, for the next cluster |
| acc_out_s | output | AW | Accumulation output, sum word |
| acc_out_c | output | AW | Accumulation output, carry word |

## Verification
A coefficient write and the shadow-to-working copy can both fall on the same phase-0-ending edge. The bench provokes this by asserting the write in the very cycle it drives a new sample. It also writes in the phase-2 cycle just before, for comparison. The bench's coefficient model applies the first kind one sample later and the second kind at once, and every merged output is compared against that model. A chained pair of clusters checks that the rotated schedule lines up the broadcast and accumulation paths.

// File: rtl/fir3_cluster.sv
module fir3_cluster #(
  parameter int DW        = 8,
  parameter int CW        = 12,
  parameter int AW        = 24,
  parameter int PHASE_OFS = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_in,
  input  logic                 coef_wr,
  input  logic [1:0]           coef_sel,
  input  logic signed [CW-1:0] coef_data,
  input  logic [AW-1:0]        acc_in_s,
  input  logic [AW-1:0]        acc_in_c,
  output logic [1:0]           phase,
  output logic signed [DW-1:0] bcast_out,
  output logic [AW-1:0]        acc_out_s,
  output logic [AW-1:0]        acc_out_c
);
  localparam int TAPS = 3;
  localparam int BDLY = 4;
  localparam int LW   = CW / 2;
  localparam int HW   = CW - LW;
  localparam logic [1:0] PH0 = 2'(PHASE_OFS % 3);

  logic signed [DW-1:0] xh [BDLY+1];
  logic signed [CW-1:0] shadow [TAPS];
  logic signed [CW-1:0] active [TAPS];
  logic signed [DW-1:0] x_sel;
  logic signed [CW-1:0] c_sel;
  logic [AW-1:0] xs, clo, chi, pp0, pp1;
  logic [AW-1:0] p0, p1, s_w, c_w;
  logic [AW-1:0] add_s, add_c, s1, k1, s_nx, c_nx;

  function automatic logic [2*AW-1:0] csa3(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                           input logic [AW-1:0] d);
    csa3 = {((a & b) | (a & d) | (b & d)) << 1, a ^ b ^ d};
  endfunction

  always_comb begin
    case (phase)
      2'd1:    begin x_sel = xh[0]; c_sel = active[0]; end
      2'd2:    begin x_sel = xh[1]; c_sel = active[1]; end
      default: begin x_sel = xh[2]; c_sel = active[2]; end
    endcase
  end

  assign xs  = {{(AW-DW){x_sel[DW-1]}}, x_sel};
  assign clo = {{(AW-LW){1'b0}}, c_sel[LW-1:0]};
  assign chi = {{(AW-HW){c_sel[CW-1]}}, c_sel[CW-1:LW]};
  assign pp0 = xs * clo;
  assign pp1 = (xs * chi) << LW;

  assign add_s = (phase == 2'd2) ? acc_in_s : s_w;
  assign add_c = (phase == 2'd2) ? acc_in_c : c_w;
  assign {k1, s1}     = csa3(p0, p1, add_s);
  assign {c_nx, s_nx} = csa3(s1, k1, add_c);

  assign bcast_out = xh[BDLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH0;
      for (int i = 0; i <= BDLY; i++) xh[i] <= '0;
      for (int i = 0; i < TAPS; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
      p0 <= '0; p1 <= '0; s_w <= '0; c_w <= '0;
      acc_out_s <= '0; acc_out_c <= '0;
    end else begin
      phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      if (coef_wr && coef_sel != 2'd3) shadow[coef_sel] <= coef_data;
      if (phase == 2'd0) begin
        xh[0] <= x_in;
        for (int i = 1; i <= BDLY; i++) xh[i] <= xh[i-1];
        for (int i = 0; i < TAPS; i++) active[i] <= shadow[i];
      end
      p0  <= pp0;
      p1  <= pp1;
      s_w <= s_nx;
      c_w <= c_nx;
      if (phase == 2'd2) begin
        acc_out_s <= s_w;
        acc_out_c <= c_w;
      end
    end
  end
endmodule

// File: rtl/fir3_cluster_chk.sv
module fir3_cluster_chk #(
  parameter int DW        = 8,
  parameter int AW        = 24,
  parameter int PHASE_OFS = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic [DW-1:0] bcast_out,
  input logic [AW-1:0] acc_out_s,
  input logic [AW-1:0] acc_out_c
);
  a_r1_start_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phase == 2'(PHASE_OFS % 3) && acc_out_s == '0 && acc_out_c == '0 && bcast_out == '0));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)));

  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phase) != 2'd2) |-> ($stable(acc_out_s) && $stable(acc_out_c)));

  a_r6_bcast_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phase) != 2'd0) |-> $stable(bcast_out));
endmodule

bind fir3_cluster fir3_cluster_chk #(.DW(DW), .AW(AW), .PHASE_OFS(PHASE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .bcast_out(bcast_out),
  .acc_out_s(acc_out_s), .acc_out_c(acc_out_c)
);

// File: tb/tb_fir3_cluster.sv
module tb_fir3_cluster;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic signed [7:0]  x_in = '0;
  logic               coef_wr = 1'b0, coef_wr2 = 1'b0;
  logic [1:0]         coef_sel = '0;
  logic signed [11:0] coef_data = '0;
  logic [AW-1:0]      acc_in_s = '0, acc_in_c = '0;
  logic [1:0]         phase, phase2;
  logic signed [7:0]  bcast, bcast2;
  logic [AW-1:0]      out_s, out_c, out2_s, out2_c;

  fir3_cluster #(.PHASE_OFS(0)) dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .coef_wr(coef_wr), .coef_sel(coef_sel),
    .coef_data(coef_data), .acc_in_s(acc_in_s), .acc_in_c(acc_in_c), .phase(phase),
    .bcast_out(bcast), .acc_out_s(out_s), .acc_out_c(out_c));

  fir3_cluster #(.PHASE_OFS(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .x_in(bcast), .coef_wr(coef_wr2), .coef_sel(coef_sel),
    .coef_data(coef_data), .acc_in_s(out_s), .acc_in_c(out_c), .phase(phase2),
    .bcast_out(bcast2), .acc_out_s(out2_s), .acc_out_c(out2_c));

  int n_chk = 0, n_bad = 0;
  int xs [0:511];
  int expv [0:511];
  string tg [0:511];
  int k = 0;
  int mact [3] = '{0, 0, 0};
  int msh [3] = '{0, 0, 0};
  int h2 [3] = '{0, 0, 0};
  bit casc = 0;
  int casc_from = 0;
  string tag = "R3";

  function automatic int xh(int i);
    return (i < 0) ? 0 : xs[i];
  endfunction

  function automatic int wrap(int v);
    logic signed [AW-1:0] t;
    t = v[AW-1:0];
    return int'(t);
  endfunction

  task automatic chk(string r, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, got, exp);
    end
  endtask

  // mode 0: no write, 1: write in the phase-2 cycle before the sample, 2: write in the sample's phase-0 cycle
  task automatic push(int xv, int av, int mode = 0, int tgt = 0, int sel = 0, int val = 0);
    logic [AW-1:0] sum;
    do @(negedge clk); while (phase != 2'd2);
    if (mode == 1) begin
      coef_sel = sel[1:0]; coef_data = val[11:0];
      if (tgt == 0) coef_wr = 1'b1; else coef_wr2 = 1'b1;
    end
    @(negedge clk);
    coef_wr = 1'b0; coef_wr2 = 1'b0;
    if (mode == 1 && tgt == 0 && sel < 3) msh[sel] = val;
    if (k >= 2) begin
      sum = out_s + out_c;
      chk(tg[k-2], wrap(int'(sum)), wrap(expv[k-2]), "acc_out");
    end
    if (k >= 5) chk("R6", int'(bcast), xh(k-5), "bcast_out");
    if (casc && k - 4 >= casc_from) begin
      int y;
      sum = out2_s + out2_c;
      y = 0;
      for (int j = 0; j < 3; j++) y += mact[j] * xh(k-4-j) + h2[j] * xh(k-7-j);
      chk("R10", wrap(int'(sum)), wrap(y), "cascade");
    end
    mact = msh;
    xs[k] = xv;
    tg[k] = tag;
    x_in = xv[7:0];
    acc_in_s = AW'(av - 777);
    acc_in_c = AW'(777);
    expv[k] = av + mact[0] * xv + mact[1] * xh(k-1) + mact[2] * xh(k-2);
    k++;
    if (mode == 2) begin
      coef_sel = sel[1:0]; coef_data = val[11:0];
      if (tgt == 0) coef_wr = 1'b1; else coef_wr2 = 1'b1;
      @(negedge clk);
      coef_wr = 1'b0; coef_wr2 = 1'b0;
      if (tgt == 0 && sel < 3) msh[sel] = val;
    end
  endtask

  task automatic t_reset;
    // R1
    chk("R1", int'(phase), 0, "phase");
    chk("R1", int'(phase2), 2, "phase of offset cluster");
    chk("R1", int'(out_s | out_c), 0, "acc_out");
    chk("R1", int'(bcast), 0, "bcast_out");
  endtask

  task automatic t_phase;
    // R2
    for (int i = 0; i < 6; i++) begin
      int prev = int'(phase);
      @(negedge clk);
      chk("R2", int'(phase), (prev + 1) % 3, "phase step");
    end
  endtask

  task automatic t_passthru;
    tag = "R5";
    push(5, 1000); push(-7, -4000); push(100, 8388000); push(1, 0);
  endtask

  task automatic t_basic;
    tag = "R3";
    push(2, 10, 1, 0, 0, 3);
    push(-1, 20, 1, 0, 1, -5);
    push(4, 30, 1, 0, 2, 7);
    for (int i = 0; i < 6; i++) push(i * 3 - 7, 50 - i);
  endtask

  task automatic t_extreme;
    tag = "R4";
    push(-128, 0, 1, 0, 0, -2048);
    push(127, 0, 1, 0, 1, 2047);
    push(-128, 0, 1, 0, 2, -2048);
    push(-128, -1); push(127, 0); push(-128, 5); push(-128, 0); push(0, 0);
  endtask

  task automatic t_commit;
    tag = "R7";
    push(9, 0, 1, 0, 0, 100);
    push(3, 0);
    tag = "R8";
    push(6, 0, 2, 0, 0, -300);
    push(-2, 0);
    push(11, 0, 2, 0, 1, 55);
    push(1, 0); push(0, 0);
  endtask

  task automatic t_ignore;
    tag = "R9";
    push(12, 4, 1, 0, 3, 1999);
    push(-9, 4, 2, 0, 3, -1999);
    push(7, 4); push(5, 4); push(0, 4);
  endtask

  task automatic t_cascade;
    tag = "R10";
    push(0, 0, 1, 0, 0, 13);
    push(0, 0, 1, 0, 1, -21);
    push(0, 0, 1, 0, 2, 34);
    push(0, 0, 1, 1, 0, -55);
    push(0, 0, 1, 1, 1, 89);
    push(0, 0, 1, 1, 2, -144);
    h2 = '{-55, 89, -144};
    casc_from = k + 2;
    casc = 1;
    for (int i = 0; i < 14; i++) push((i * 37) % 256 - 128, 0);
    for (int i = 0; i < 6; i++) push(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_phase;
    t_passthru;
    t_basic;
    t_extreme;
    t_commit;
    t_ignore;
    t_cascade;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule